// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the pending-event flags and the per-event enable mask for a 16-bit timer/counter that owns an input-capture unit and two compare channels. Four hardware sources feed it: counter overflow, a match on compare channel A, a match on channel B, and a capture event. The capture flag takes its event from one of two places. Normally it is the capture pin event. When the capture register is serving as the counter's TOP value, it is instead the moment the counter reaches TOP. Every event input counts only on cycles where the timer clock-enable tick is high.

Software reads and writes the flag register and the enable register through a small synchronous bus port. Writing a one to a flag clears it. A flag also clears when the interrupt controller acknowledges that source's vector. A hardware set that lands in the same cycle as a clear wins, so no event is lost. Each of the four request lines is registered, and is high when that source's flag, its enable bit and the global interrupt enable were all one on the previous cycle.

Top module: `tirq_unit`

## Requirements
- R1: After a synchronous reset, every flag, every enable bit, all four request lines and the read data are zero.
- R2: Both registers share one 8-bit layout: overflow at bit 0, compare A at bit 1, compare B at bit 2, capture at bit 5. Bits 7:6 and 4:3 always read zero and ignore writes.
- R3: A write with bus_sel=0 clears each flag whose data bit is one and leaves the others alone. A write with bus_sel=1 loads the enable register from the four mapped data bits.
- R4: Asserting a source's bit of vec_ack (bit 0 overflow, 1 compare A, 2 compare B, 3 capture) clears that flag at the next clock edge.
- R5: When a hardware set and a clear (write-one or acknowledge) for the same flag arrive in one cycle, the flag ends up set.
- R6: A compare flag is set at the end of the next tick cycle after the tick cycle on which its match input was high. It is not set at the end of the match tick itself.
- R7: A match seen on a tick together with that channel's force strobe never sets the compare flag.
- R8: With cap_is_top=0 the capture flag is set by cap_evt on a tick. With cap_is_top=1 it is set by at_top on a tick, and cap_evt is ignored.
- R9: The overflow flag is set at the end of a tick cycle on which ovf_evt is high.
- R10: Event, match and force inputs on cycles with tick=0 have no effect on any flag.
- R11: irq[k] equals the AND of flag k, enable k and gie as sampled at the previous clock edge (irq bit order as in R4).
- R12: When bus_re is high, bus_rdata loads the register chosen by bus_sel (0 flags, 1 enables) at the next edge. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock-enable qualifier |
| ovf_evt | input | 1 | Counter overflow event |
| cmp_a_match | input | 1 | Counter equals compare A |
| cmp_b_match | input | 1 | Counter equals compare B |
| force_a | input | 1 | Forced compare strobe, channel A |
| force_b | input | 1 | Forced compare strobe, channel B |
| cap_evt | input | 1 | Capture pin event |
| at_top | input | 1 | Counter has reached TOP |
| cap_is_top | input | 1 | Capture register is used as TOP |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | 4 | Per-source vector acknowledge |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_sel | input | 1 | 0 selects flags, 1 selects enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 4 | Registered interrupt requests |

## Verification
The hardest case is a compare match whose flag set is deferred to a later tick, while a write-one or an acknowledge for that same flag arrives in exactly that later tick cycle. Tick gaps of random length sit between the two ticks, and force strobes may overlap the match. Random stimulus with tick at about half density, frequent acknowledges and frequent flag writes produces many such overlaps. Directed sequences also place a match on one tick, idle cycles, and then a clear coinciding with the next tick. A cycle model in the bench tracks the pending match of each channel separately.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int NSRC   = 4;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SRC_OVF  = 2'd0,
    SRC_CMPA = 2'd1,
    SRC_CMPB = 2'd2,
    SRC_CAP  = 2'd3
  } src_e;

  // register bit position of each source (shared by flag and enable regs)
  function automatic int src_bit(input int s);
    case (s)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 5;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pack_src(input logic [NSRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int s = 0; s < NSRC; s++) r[src_bit(s)] = v[s];
    return r;
  endfunction

  function automatic logic [NSRC-1:0] unpack_src(input logic [DATA_W-1:0] d);
    logic [NSRC-1:0] r;
    for (int s = 0; s < NSRC; s++) r[s] = d[src_bit(s)];
    return r;
  endfunction
endpackage

// File: rtl/tirq_cmp_defer.sv
// Holds a compare match seen on one tick and releases it as a set pulse
// on the following tick. A forced strobe on the match tick discards it.
module tirq_cmp_defer #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [NCH-1:0] match,
  input  logic [NCH-1:0] force_stb,
  output logic [NCH-1:0] set_out
);
  logic [NCH-1:0] pend_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)       pend_q[c] <= 1'b0;
      else if (tick) pend_q[c] <= match[c] & ~force_stb[c];
    end
    assign set_out[c] = tick & pend_q[c];
  end
endmodule

// File: rtl/tirq_src_select.sv
// Builds the per-source hardware set vector from the event inputs.
module tirq_src_select
  import tirq_pkg::*;
(
  input  logic            tick,
  input  logic            ovf_evt,
  input  logic            cap_evt,
  input  logic            at_top,
  input  logic            cap_is_top,
  input  logic [1:0]      cmp_set,
  output logic [NSRC-1:0] hw_set
);
  logic cap_src;

  always_comb begin
    cap_src            = cap_is_top ? at_top : cap_evt;
    hw_set             = '0;
    hw_set[SRC_OVF]    = tick & ovf_evt;
    hw_set[SRC_CMPA]   = cmp_set[0];
    hw_set[SRC_CMPB]   = cmp_set[1];
    hw_set[SRC_CAP]    = tick & cap_src;
  end
endmodule

// File: rtl/tirq_flag_bank.sv
// Flag storage: set has priority over write-one-clear and acknowledge.
module tirq_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] flag_q
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flag_q[k] <= 1'b0;
      else if (hw_set[k]) flag_q[k] <= 1'b1;
      else if (sw_clr[k] | ack_clr[k]) flag_q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/tirq_unit.sv
module tirq_unit
  import tirq_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            ovf_evt,
  input  logic            cmp_a_match,
  input  logic            cmp_b_match,
  input  logic            force_a,
  input  logic            force_b,
  input  logic            cap_evt,
  input  logic            at_top,
  input  logic            cap_is_top,
  input  logic            gie,
  input  logic [NSRC-1:0] vec_ack,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic            bus_sel,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  output logic [NSRC-1:0] irq
);
  localparam logic SEL_FLAG = 1'b0;
  localparam logic SEL_EN   = 1'b1;

  logic [1:0]      cmp_set;
  logic [NSRC-1:0] hw_set;
  logic [NSRC-1:0] sw_clr;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] wr_bits;

  tirq_cmp_defer #(.NCH(2)) u_defer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .match     ({cmp_b_match, cmp_a_match}),
    .force_stb ({force_b, force_a}),
    .set_out   (cmp_set)
  );

  tirq_src_select u_sel (
    .tick       (tick),
    .ovf_evt    (ovf_evt),
    .cap_evt    (cap_evt),
    .at_top     (at_top),
    .cap_is_top (cap_is_top),
    .cmp_set    (cmp_set),
    .hw_set     (hw_set)
  );

  assign wr_bits = unpack_src(bus_wdata[DATA_W-1:0]);
  assign sw_clr  = (bus_we && bus_sel == SEL_FLAG) ? wr_bits : '0;

  tirq_flag_bank #(.N(NSRC)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .hw_set  (hw_set),
    .sw_clr  (sw_clr),
    .ack_clr (vec_ack),
    .flag_q  (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                               en_q <= '0;
    else if (bus_we && bus_sel == SEL_EN)  en_q <= wr_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= flag_q & en_q & {NSRC{gie}};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= (bus_sel == SEL_EN) ? pack_src(en_q) : pack_src(flag_q);
  end
endmodule

// File: rtl/tirq_unit_chk.sv
module tirq_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       ovf_evt,
  input logic       gie,
  input logic [3:0] vec_ack,
  input logic [3:0] flag_q,
  input logic [7:0] bus_rdata,
  input logic [3:0] irq
);
  // R2: reserved positions never read as one
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & 8'hD8) == 8'h00);

  // R10: a flag only rises after a tick cycle
  assert_rise_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & ~$past(flag_q)) != 4'b0) |-> $past(tick));

  // R4: acknowledged overflow flag drops unless set again
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (vec_ack[0] && !(tick && ovf_evt)) |=> !flag_q[0]);

  // R5: overflow set beats a simultaneous acknowledge
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && ovf_evt) |=> flag_q[0]);

  // R11: no request while global enable was low
  assert_gie_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !gie |=> irq == 4'b0);

  // R11: a request needs the flag one cycle earlier
  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(flag_q)) == 4'b0));
endmodule

bind tirq_unit tirq_unit_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .ovf_evt   (ovf_evt),
  .gie       (gie),
  .vec_ack   (vec_ack),
  .flag_q    (flag_q),
  .bus_rdata (bus_rdata),
  .irq       (irq)
);

// File: tb/test_tirq_unit.sv
module test_tirq_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick, ovf_evt, cmp_a_match, cmp_b_match, force_a, force_b;
  logic       cap_evt, at_top, cap_is_top, gie;
  logic [3:0] vec_ack;
  logic       bus_we, bus_re, bus_sel;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] irq;

  int vectors = 0;
  int errors  = 0;
  string tag = "R1";

  // model state
  logic [3:0] m_flag, m_en, m_irq;
  logic       m_pa, m_pb;
  logic [7:0] m_rd;

  always #10 clk = ~clk;

  tirq_unit i_tirq_unit (
    .clk(clk), .rst(rst), .tick(tick), .ovf_evt(ovf_evt),
    .cmp_a_match(cmp_a_match), .cmp_b_match(cmp_b_match),
    .force_a(force_a), .force_b(force_b), .cap_evt(cap_evt), .at_top(at_top),
    .cap_is_top(cap_is_top), .gie(gie), .vec_ack(vec_ack), .bus_we(bus_we),
    .bus_re(bus_re), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] to_reg(input logic [3:0] v);
    return {2'b00, v[3], 2'b00, v[2], v[1], v[0]};
  endfunction

  function automatic logic [3:0] from_reg(input logic [7:0] d);
    return {d[5], d[2], d[1], d[0]};
  endfunction

  task automatic idle_inputs();
    tick = 0; ovf_evt = 0; cmp_a_match = 0; cmp_b_match = 0; force_a = 0;
    force_b = 0; cap_evt = 0; at_top = 0; vec_ack = 0; bus_we = 0;
    bus_re = 0; bus_sel = 0; bus_wdata = 0;
  endtask

  task automatic compare();
    vectors++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL %s R11 irq: got %b expected %b", tag, irq, m_irq);
    end
    vectors++;
    if (bus_rdata !== m_rd) begin
      errors++;
      $display("FAIL %s R12 rdata: got %h expected %h", tag, bus_rdata, m_rd);
    end
  endtask

  // advance the model by one clock using the inputs now driven
  task automatic model_step();
    logic [3:0] set, clr, nflag;
    set    = 4'b0;
    set[0] = tick & ovf_evt;
    set[1] = tick & m_pa;
    set[2] = tick & m_pb;
    set[3] = tick & (cap_is_top ? at_top : cap_evt);
    clr    = vec_ack | ((bus_we && !bus_sel) ? from_reg(bus_wdata) : 4'b0);
    nflag  = set | (m_flag & ~clr);
    m_irq  = m_flag & m_en & {4{gie}};
    if (bus_re) m_rd = bus_sel ? to_reg(m_en) : to_reg(m_flag);
    if (bus_we && bus_sel) m_en = from_reg(bus_wdata);
    if (tick) begin
      m_pa = cmp_a_match & ~force_a;
      m_pb = cmp_b_match & ~force_b;
    end
    m_flag = nflag;
  endtask

  // inputs are already set; run one clock, then check at the falling edge
  task automatic cycle();
    model_step();
    @(negedge clk);
    compare();
    idle_inputs();
  endtask

  task automatic read_reg(input logic sel, input string t);
    tag = t; bus_re = 1; bus_sel = sel; cycle();
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d, input string t);
    tag = t; bus_we = 1; bus_sel = sel; bus_wdata = d; cycle();
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle_inputs(); gie = 0; cap_is_top = 0; rst = 1;
    m_flag = 0; m_en = 0; m_irq = 0; m_pa = 0; m_pb = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1"; compare();             // R1 reset state
    read_reg(1, "R1"); read_reg(0, "R1");

    // R2 R3: enable layout, reserved bits ignored on write
    write_reg(1, 8'hFF, "R2"); read_reg(1, "R2");
    gie = 1;
    // R9: overflow on tick
    tag = "R9"; tick = 1; ovf_evt = 1; cycle(); read_reg(0, "R9");
    // R10: events without tick
    tag = "R10"; ovf_evt = 1; cmp_a_match = 1; cap_evt = 1; at_top = 1; cycle();
    tick = 1; cycle(); read_reg(0, "R10");
    // R3: write zero keeps, write one clears
    write_reg(0, 8'h00, "R3"); read_reg(0, "R3");
    write_reg(0, 8'h01, "R3"); read_reg(0, "R3");
    // R6: match, gap, next tick sets
    tag = "R6"; tick = 1; cmp_a_match = 1; cycle(); read_reg(0, "R6");
    cycle(); cycle(); read_reg(0, "R6");
    tick = 1; cycle(); read_reg(0, "R6");
    // R7: forced match does not set
    tag = "R7"; tick = 1; cmp_b_match = 1; force_b = 1; cycle();
    tick = 1; cycle(); read_reg(0, "R7");
    // R8: capture source by mode
    cap_is_top = 1; tag = "R8"; tick = 1; cap_evt = 1; cycle(); read_reg(0, "R8");
    tick = 1; at_top = 1; cycle(); read_reg(0, "R8");
    // R4: acknowledge clears
    tag = "R4"; vec_ack = 4'b1010; cycle(); read_reg(0, "R4");
    // R5: deferred compare set collides with write-one-clear
    tag = "R5"; tick = 1; cmp_a_match = 1; cycle(); cycle();
    tick = 1; bus_we = 1; bus_sel = 0; bus_wdata = 8'h02; vec_ack = 4'b0010;
    cycle(); read_reg(0, "R5");
    tick = 1; ovf_evt = 1; vec_ack = 4'b0001; cycle(); read_reg(0, "R5");
    // R11: gie gating
    tag = "R11"; gie = 0; cycle(); cycle(); gie = 1; cycle(); cycle();

    // random phase
    tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      tick        = r[0];
      ovf_evt     = r[1] & r[2];
      cmp_a_match = r[3];
      cmp_b_match = r[4];
      force_a     = r[5] & r[6];
      force_b     = r[7] & r[8];
      cap_evt     = r[9] & r[10];
      at_top      = r[11] & r[12];
      vec_ack     = r[16:13] & r[20:17];
      bus_we      = r[21] & r[22];
      bus_re      = r[23];
      bus_sel     = r[24];
      bus_wdata   = $urandom;
      if (r[31:27] == 0) cap_is_top = ~cap_is_top;
      gie = (r[26:25] != 0);
      cycle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule